// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block gives on-chip logic a clocked request port to an external asynchronous static RAM of 256K words by 16 bits. A host presents an 18-bit word address, a write flag, a 2-bit byte enable and write data under a valid/ready handshake. The controller then runs one memory cycle on the active-low chip select, write enable, output enable and the two byte-lane strobes. A read returns its data together with a one-clock done pulse.

Every phase length is a clock count set by a parameter. The defaults meet the 10 ns speed grade at 100 MHz: a two-clock read, a two-clock write-enable pulse and a one-clock recovery. Writes are controlled by write enable. Output enable stays high for the whole write. The data drivers turn on one clock after write enable falls and turn off on the edge that raises it, so the controller and the memory never drive the data pins at the same time.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0, sram_dq_oe is 0, and chip select, write enable, output enable and both lane strobes are all 1.
- R2: A request is taken only on a clock where req_valid and req_ready are both 1. req_ready is 1 only in the idle state. After an accepted access, rsp_done pulses for one clock at the end of the access phase, and req_ready returns TURNAROUND clocks later.
- R3: A read holds chip select and output enable at 0 and write enable at 1 for READ_CYC clocks. The lane strobes are sram_lb_n = ~be[0] (bits 7:0) and sram_ub_n = ~be[1] (bits 15:8).
- R4: Read data is captured on the last clock of the read phase and appears on rsp_rdata with the done pulse. A lane whose byte-enable bit is 0 reads as zero.
- R5: A write holds chip select and write enable at 0 for WE_PULSE clocks, with output enable at 1 for the whole cycle. Only the lanes selected by req_be change in memory.
- R6: sram_dq_oe goes to 1 one clock after write enable falls and returns to 0 on the edge where write enable rises. While it is 1, sram_dq_out carries the request's write data. It is never 1 while output enable is 0.
- R7: sram_addr equals the accepted address throughout the access and changes only while chip select is 1.
- R8: A request with req_be = 2'b00 asserts no strobe, produces rsp_done on the clock after acceptance, and leaves req_ready at 1 and memory unchanged.
- R9: Whenever chip select is 1, write enable, output enable and both lane strobes are also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | 18 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enable; bit 0 low lane, bit 1 high lane |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| rsp_done | output | 1 | One-clock completion pulse |
| sram_addr | output | 18 | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Low-lane strobe, active low |
| sram_ub_n | output | 1 | High-lane strobe, active low |
| sram_dq_out | output | 16 | Data to memory |
| sram_dq_oe | output | 1 | Enable for the data drivers |
| sram_dq_in | input | 16 | Data from memory |

## Verification
If the state or phase counter is wrong, the done pulse arrives on the wrong clock, or ready returns on the wrong clock, in the same access. Both are measured against READ_CYC, WE_PULSE and TURNAROUND on every request. If the lane register is wrong, the strobes no longer match the byte enable. A wrong mask or capture shows up as a corrupted or unmasked byte at the next read of that word. A drive-enable error shows up as contention with the memory's outputs, checked on every clock.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_WRITE   = 2'd2,
        ST_RECOVER = 2'd3
    } sram_state_e;
endpackage

// File: rtl/sram_phase_count.sv
// Down-counter for the phase lengths; expired flags a count of zero.
module sram_phase_count #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_map.sv
// Per-lane strobe generation and read-data masking.
module sram_lane_map #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic [LANES-1:0] be,
    input  logic             active,
    input  logic [DW-1:0]    din,
    output logic [LANES-1:0] strobe_n,
    output logic [DW-1:0]    rd_masked
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strobe_n[i] = ~(active & be[i]);
        assign rd_masked[i*LANE_W +: LANE_W] = be[i] ? din[i*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int LANE_W     = 8,
    parameter int READ_CYC   = 2,
    parameter int WE_PULSE   = 2,
    parameter int TURNAROUND = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    input  logic [1:0]            req_be,
    input  logic [2*LANE_W-1:0]   req_wdata,
    output logic [2*LANE_W-1:0]   rsp_rdata,
    output logic                  rsp_done,
    output logic [ADDR_W-1:0]     sram_addr,
    output logic                  sram_cs_n,
    output logic                  sram_we_n,
    output logic                  sram_oe_n,
    output logic                  sram_lb_n,
    output logic                  sram_ub_n,
    output logic [2*LANE_W-1:0]   sram_dq_out,
    output logic                  sram_dq_oe,
    input  logic [2*LANE_W-1:0]   sram_dq_in
);
    localparam int LANES   = 2;
    localparam int DW      = LANES * LANE_W;
    // Clamp: reads and recovery need one clock, a write needs two so data is driven.
    localparam int RD_LEN  = (READ_CYC   < 1) ? 1 : READ_CYC;
    localparam int WE_LEN  = (WE_PULSE   < 2) ? 2 : WE_PULSE;
    localparam int TA_LEN  = (TURNAROUND < 1) ? 1 : TURNAROUND;
    localparam int MAX_LEN = (RD_LEN > WE_LEN) ? ((RD_LEN > TA_LEN) ? RD_LEN : TA_LEN)
                                               : ((WE_LEN > TA_LEN) ? WE_LEN : TA_LEN);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_LEN - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_LEN - 1);

    typedef struct packed {
        sram_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     rdata;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  lane_n;
        logic              drive;
        logic              done;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             cnt_expired;
    logic [LANES-1:0] be_sel;
    logic             lane_active;
    logic [LANES-1:0] lane_strobe_n;
    logic [DW-1:0]    rd_masked;

    sram_phase_count #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .expired  (cnt_expired)
    );

    sram_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .be        (be_sel),
        .active    (lane_active),
        .din       (sram_dq_in),
        .strobe_n  (lane_strobe_n),
        .rd_masked (rd_masked)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        be_sel       = r_q.be;
        lane_active  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_be == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.addr    = req_addr;
                        r_d.be      = req_be;
                        r_d.wdata   = req_wdata;
                        r_d.cs_n    = 1'b0;
                        be_sel      = req_be;
                        lane_active = 1'b1;
                        cnt_load    = 1'b1;
                        if (req_write) begin
                            r_d.state    = ST_WRITE;
                            r_d.we_n     = 1'b0;
                            cnt_load_val = WE_LOAD;
                        end else begin
                            r_d.state    = ST_READ;
                            r_d.oe_n     = 1'b0;
                            cnt_load_val = RD_LOAD;
                        end
                    end
                end
            end
            ST_READ: begin
                lane_active = 1'b1;
                if (cnt_expired) begin
                    r_d.rdata    = rd_masked;
                    r_d.done     = 1'b1;
                    r_d.cs_n     = 1'b1;
                    r_d.oe_n     = 1'b1;
                    lane_active  = 1'b0;
                    r_d.state    = ST_RECOVER;
                    cnt_load     = 1'b1;
                    cnt_load_val = TA_LOAD;
                end
            end
            ST_WRITE: begin
                lane_active = 1'b1;
                r_d.drive   = 1'b1;
                if (cnt_expired) begin
                    r_d.drive    = 1'b0;
                    r_d.we_n     = 1'b1;
                    r_d.cs_n     = 1'b1;
                    r_d.done     = 1'b1;
                    lane_active  = 1'b0;
                    r_d.state    = ST_RECOVER;
                    cnt_load     = 1'b1;
                    cnt_load_val = TA_LOAD;
                end
            end
            ST_RECOVER: begin
                if (cnt_expired) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase

        r_d.lane_n = lane_strobe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.cs_n   <= 1'b1;
            r_q.we_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
            r_q.lane_n <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.state == ST_IDLE);
    assign rsp_rdata   = r_q.rdata;
    assign rsp_done    = r_q.done;
    assign sram_addr   = r_q.addr;
    assign sram_cs_n   = r_q.cs_n;
    assign sram_we_n   = r_q.we_n;
    assign sram_oe_n   = r_q.oe_n;
    assign sram_lb_n   = r_q.lane_n[0];
    assign sram_ub_n   = r_q.lane_n[1];
    assign sram_dq_out = r_q.wdata;
    assign sram_dq_oe  = r_q.drive;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_lb_n,
    input logic              sram_ub_n,
    input logic              sram_dq_oe
);
    assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> sram_cs_n);

    assert_cs_gates_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs_n |-> (sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n));

    assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    assert_drive_after_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> ($past(!sram_we_n) && !sram_we_n));

    assert_release_with_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> !sram_dq_oe);

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_oe_n && !sram_we_n && !sram_cs_n));

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .sram_addr  (sram_addr),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_lb_n  (sram_lb_n),
    .sram_ub_n  (sram_ub_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
    localparam int RC = 2;
    localparam int WP = 2;
    localparam int TA = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_done;
    logic [17:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_in;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [15:0] mem  [64];
    logic [15:0] shad [64];

    always #4 clk = ~clk;

    sram_lane_ctrl #(.READ_CYC(RC), .WE_PULSE(WP), .TURNAROUND(TA)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // Memory model: drives only enabled lanes during a read; floating lanes read A5.
    wire mem_drives = !sram_cs_n && !sram_oe_n && sram_we_n;
    assign sram_dq_in[7:0]  = (mem_drives && !sram_lb_n) ? mem[sram_addr[5:0]][7:0]  : 8'hA5;
    assign sram_dq_in[15:8] = (mem_drives && !sram_ub_n) ? mem[sram_addr[5:0]][15:8] : 8'hA5;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_cs_n && !sram_we_n && sram_dq_oe) begin
                if (!sram_lb_n) mem[sram_addr[5:0]][7:0]  <= sram_dq_out[7:0];
                if (!sram_ub_n) mem[sram_addr[5:0]][15:8] <= sram_dq_out[15:8];
            end
            if (sram_dq_oe && mem_drives)
                chk(1'b0, "R6 bus contention", 32'(sram_dq_oe), 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=finish", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic do_req(input logic [17:0] a, input bit wr, input logic [1:0] be,
                          input logic [15:0] wd, output logic [15:0] rd);
        int n, j, k, we_cnt, drv_cnt;
        bit bad_oe, bad_lane, bad_addr, bad_dq, bad_cs;
        n = (be == 2'b00) ? 0 : (wr ? WP : RC);
        j = 0; k = 0; we_cnt = 0; drv_cnt = 0;
        bad_oe = 0; bad_lane = 0; bad_addr = 0; bad_dq = 0; bad_cs = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done && j < 60) begin
            if (!sram_we_n) we_cnt++;
            if (sram_dq_oe) begin
                drv_cnt++;
                if (sram_dq_out != wd) bad_dq = 1;
            end
            if (sram_cs_n) bad_cs = 1;
            if (sram_addr != a) bad_addr = 1;
            if ({sram_ub_n, sram_lb_n} != ~be) bad_lane = 1;
            if (wr && !sram_oe_n) bad_oe = 1;
            if (!wr && (sram_oe_n || !sram_we_n)) bad_oe = 1;
            j++;
            @(negedge clk);
        end
        chk(j == n, "R2 done latency", j, n);
        rd = rsp_rdata;
        if (be == 2'b00) begin
            chk(req_ready && sram_cs_n && sram_lb_n && sram_ub_n, "R8 zero-enable no strobe",
                {req_ready, sram_cs_n, sram_lb_n, sram_ub_n}, 4'hF);
        end else begin
            chk(!bad_cs && !bad_oe, wr ? "R5 write strobes" : "R3 read strobes", {bad_cs, bad_oe}, 0);
            chk(!bad_lane, "R3 lane strobes", be, be);
            chk(!bad_addr, "R7 address held", sram_addr, a);
            chk(we_cnt == (wr ? WP : 0), "R5 we pulse length", we_cnt, wr ? WP : 0);
            chk(drv_cnt == (wr ? WP - 1 : 0) && !bad_dq, "R6 drive window", drv_cnt, wr ? WP - 1 : 0);
            chk(sram_cs_n && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n && !sram_dq_oe,
                "R9 strobes released", {sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n}, 5'h1F);
            while (!req_ready && k < 60) begin
                k++;
                @(negedge clk);
            end
            chk(k == TA, "R2 ready return", k, TA);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] be);
        return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
    endfunction

    function automatic logic [15:0] mask(input logic [15:0] v, input logic [1:0] be);
        return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
    endfunction

    function automatic logic [17:0] addr_of(input int i);
        return (i[0] ? 18'h3FFC0 : 18'h00000) | 18'(i);
    endfunction

    initial begin
        logic [15:0] rd;
        for (int i = 0; i < 64; i++) begin
            mem[i] = 16'h0000;
            shad[i] = 16'h0000;
        end
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_done && !sram_dq_oe && sram_cs_n && sram_we_n && sram_oe_n
            && sram_lb_n && sram_ub_n, "R1 reset state",
            {req_ready, rsp_done, sram_dq_oe, sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n}, 8'h9F);
        rst_n = 1'b1;

        // Full-word writes then reads.
        for (int i = 0; i < 16; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h1357) ^ 16'hA0A0;
            do_req(addr_of(i), 1'b1, 2'b11, v, rd);
            shad[i] = v;
        end
        for (int i = 0; i < 16; i++) begin
            do_req(addr_of(i), 1'b0, 2'b11, 16'h0, rd);
            chk(rd == shad[i], "R4 full read", rd, shad[i]);
        end

        // Partial-lane writes, then reads under every nonzero enable.
        for (int i = 0; i < 16; i++) begin
            logic [15:0] v;
            logic [1:0]  be;
            v  = 16'(i * 16'h0F1D) + 16'h5C3B;
            be = 2'(i);
            do_req(addr_of(i), 1'b1, be, v, rd);
            shad[i] = merge(shad[i], v, be);
        end
        for (int i = 0; i < 16; i++) begin
            for (int b = 1; b < 4; b++) begin
                do_req(addr_of(i), 1'b0, 2'(b), 16'h0, rd);
                chk(rd == mask(shad[i], 2'(b)), b == 3 ? "R5 lane write" : "R4 lane mask",
                    rd, mask(shad[i], 2'(b)));
            end
        end

        // Zero enable: no strobe, memory untouched.
        do_req(addr_of(3), 1'b1, 2'b00, 16'hDEAD, rd);
        do_req(addr_of(4), 1'b0, 2'b00, 16'h0, rd);
        do_req(addr_of(3), 1'b0, 2'b11, 16'h0, rd);
        chk(rd == shad[3], "R8 memory unchanged", rd, shad[3]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule